// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter that advances once for every pulse of a 32 kHz tick enable. Software sets it up through three word registers on a simple write/read bus: a mode word (enable and a 4-bit interval code), a configuration word (expiry action and the sticky interrupt flag), and a command word that carries the feed (restart) command. Every write to the mode or configuration word must carry a 16-bit key in its upper half; a write without the key changes nothing. A feed counts only when it carries its own 12-bit key together with the restart bit.

The interval code selects the timeout from a fixed, non-linear table that runs from half a second to sixteen seconds. When the count runs out, the block does one of two things. It can drive a system-reset pulse of a fixed number of clock cycles and then switch itself off. It can instead raise a sticky interrupt and start a new period at once. A tick-count parameter sets the number of ticks in half a second, so a fast test configuration keeps the same table shape.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the block is disabled with interval code 0 and the reset action selected. `wdt_rst_o` and `wdt_irq_o` are low, the mode word reads 0 and the configuration word reads 0x0000_0001.
- R2: A write to the mode word (address 0) or to the configuration word (address 1) whose bits [31:16] differ from 0x16AA is discarded. State and outputs stay as they were.
- R3: A keyed mode write with bit 0 (enable) set loads the timeout selected by bits [7:4] and starts the countdown. The expiry lands on the clock edge of the T-th tick after the write edge, where T is the timeout in ticks.
- R4: The timeout in half-seconds is 1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28, 32 for codes 0x0 to 0xB. The reserved codes 0xC to 0xF give 32, the same as 0xB. The timeout in ticks is that number times HALF_TICKS (16000 by default).
- R5: A write to the command word (address 2) with bits [12:1] = 0xA57 and bit 0 = 1 reloads the full selected timeout while the block is enabled. A command write with any other key, or a feed while the block is disabled, has no effect.
- R6: A keyed mode write with bit 0 clear stops the counter at once. No expiry follows.
- R7: When configuration bit 0 is 1 (reset action), an expiry drives `wdt_rst_o` high for exactly PULSE_CYCLES clock cycles, starting after the expiry edge. The same expiry clears the enable bit.
- R8: When configuration bit 0 is 0 (interrupt action), an expiry sets the sticky `wdt_irq_o`, leaves `wdt_rst_o` low and reloads the counter so that the next period starts at once. A keyed configuration write with bit 8 set clears the flag.
- R9: The counter moves only in clock cycles where `tick_i` is high.
- R10: Reads are combinational. The mode word returns the code at [7:4] and the enable at [0]. The configuration word returns the action at [0] and the interrupt flag at [8]. Key fields, the command word and address 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable from the 32 kHz tick source |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | 2 | Word select: 0 mode, 1 configuration, 2 command |
| bus_wdata_i | input | 32 | Write data, including key fields |
| bus_rdata_o | output | 32 | Read data for the selected word |
| wdt_rst_o | output | 1 | System-reset pulse on expiry |
| wdt_irq_o | output | 1 | Sticky expiry interrupt |

## Verification
A corrupted count or a wrong table entry moves the edge of `wdt_rst_o` or `wdt_irq_o` away from the exact tick the bench predicts. The error therefore shows within one timeout period, and the bench checks the cycle before the expected edge as well as the edge itself. A key comparator that is too loose shows up in the mode or configuration readback on the next cycle, or as an expiry that should never occur. A pulse counter that is off by one changes the width of the reset pulse, which both the bench and a checker counter measure.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int BUS_W = 32;

    // Key fields.
    localparam logic [15:0] WR_KEY = 16'h16AA;
    localparam logic [11:0] FEED_KEY = 12'hA57;

    // Bit positions that software and the bench rely on.
    localparam int EN_BIT = 0;
    localparam int CODE_LSB = 4;
    localparam int CODE_W = 4;
    localparam int ACT_BIT = 0;
    localparam int IRQ_BIT = 8;
    localparam int RESTART_BIT = 0;

    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_CFG = 2'd1,
        REG_CTL = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // Timeout in half-second units for each interval code.
    function automatic logic [5:0] code_halves(input logic [CODE_W-1:0] code);
        logic [5:0] h;
        case (code)
            4'h0: h = 6'd1;
            4'h1: h = 6'd2;
            4'h2: h = 6'd4;
            4'h3: h = 6'd6;
            4'h4: h = 6'd8;
            4'h5: h = 6'd10;
            4'h6: h = 6'd12;
            4'h7: h = 6'd16;
            4'h8: h = 6'd20;
            4'h9: h = 6'd24;
            4'hA: h = 6'd28;
            default: h = 6'd32;
        endcase
        return h;
    endfunction
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic              expire_i,
    input  logic              irq_i,
    output logic              en_o,
    output logic [CODE_W-1:0] code_o,
    output logic              rst_sel_o,
    output logic              load_o,
    output logic [CODE_W-1:0] load_code_o,
    output logic              halt_o,
    output logic              irq_clr_o,
    output logic [BUS_W-1:0]  rdata_o
);
    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
        logic              rst_sel;
    } regs_t;

    regs_t state_d, state_q;
    logic key_ok, feed_ok, mode_wr, cfg_wr, feed_wr;
    logic unused_bits;

    assign unused_bits = ^{wdata_i[15:13], wdata_i[3:1], wdata_i[BUS_W-1:16]};

    always_comb begin
        key_ok  = (wdata_i[31:16] == WR_KEY);
        feed_ok = (wdata_i[12:1] == FEED_KEY) && wdata_i[RESTART_BIT];
        mode_wr = wr_i && (reg_sel_e'(addr_i) == REG_MODE) && key_ok;
        cfg_wr  = wr_i && (reg_sel_e'(addr_i) == REG_CFG) && key_ok;
        feed_wr = wr_i && (reg_sel_e'(addr_i) == REG_CTL) && feed_ok;

        state_d = state_q;
        if (expire_i && state_q.rst_sel) begin
            state_d.en = 1'b0;
        end
        if (mode_wr) begin
            state_d.en   = wdata_i[EN_BIT];
            state_d.code = wdata_i[CODE_LSB +: CODE_W];
        end
        if (cfg_wr) begin
            state_d.rst_sel = wdata_i[ACT_BIT];
        end

        load_o      = (mode_wr && wdata_i[EN_BIT]) || (feed_wr && state_q.en);
        load_code_o = mode_wr ? wdata_i[CODE_LSB +: CODE_W] : state_q.code;
        halt_o      = mode_wr && !wdata_i[EN_BIT];
        irq_clr_o   = cfg_wr && wdata_i[IRQ_BIT];

        rdata_o = '0;
        case (reg_sel_e'(addr_i))
            REG_MODE: begin
                rdata_o[EN_BIT] = state_q.en;
                rdata_o[CODE_LSB +: CODE_W] = state_q.code;
            end
            REG_CFG: begin
                rdata_o[ACT_BIT] = state_q.rst_sel;
                rdata_o[IRQ_BIT] = irq_i;
            end
            default: rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{en: 1'b0, code: '0, rst_sel: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    assign en_o      = state_q.en;
    assign code_o    = state_q.code;
    assign rst_sel_o = state_q.rst_sel;
endmodule

// File: rtl/kwd_timer.sv
module kwd_timer
    import kwd_pkg::*;
#(
    parameter int HALF_TICKS = 16000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              load_i,
    input  logic [CODE_W-1:0] load_code_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              halt_i,
    output logic              expire_o
);
    localparam int MAX_TICKS = 32 * HALF_TICKS;
    localparam int CNT_W = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t state_d, state_q;

    function automatic logic [CNT_W-1:0] ticks_for(input logic [CODE_W-1:0] code);
        return CNT_W'(HALF_TICKS * int'(code_halves(code)));
    endfunction

    always_comb begin
        state_d  = state_q;
        expire_o = 1'b0;
        if (halt_i) begin
            state_d.cnt = '0;
        end else if (load_i) begin
            state_d.cnt = ticks_for(load_code_i);
        end else if (run_i && tick_i) begin
            if (state_q.cnt <= CNT_W'(1)) begin
                expire_o    = 1'b1;
                state_d.cnt = ticks_for(code_i);
            end else begin
                state_d.cnt = state_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/kwd_expiry.sv
module kwd_expiry #(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic expire_i,
    input  logic rst_sel_i,
    input  logic irq_clr_i,
    output logic rst_o,
    output logic irq_o
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);

    typedef struct packed {
        logic [PW-1:0] pulse;
        logic          irq;
    } exp_t;

    exp_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.pulse != '0) begin
            state_d.pulse = state_q.pulse - PW'(1);
        end
        if (expire_i && rst_sel_i) begin
            state_d.pulse = PW'(PULSE_CYCLES);
        end
        if (irq_clr_i) begin
            state_d.irq = 1'b0;
        end
        if (expire_i && !rst_sel_i) begin
            state_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rst_o = (state_q.pulse != '0);
    assign irq_o = state_q.irq;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int HALF_TICKS = 16000,
    parameter int PULSE_CYCLES = 4
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        tick_i,
    input  logic        bus_wr_i,
    input  logic [1:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        wdt_rst_o,
    output logic        wdt_irq_o
);
    logic              mode_en;
    logic [CODE_W-1:0] mode_code;
    logic              rst_sel;
    logic              load;
    logic [CODE_W-1:0] load_code;
    logic              halt;
    logic              irq_clr;
    logic              expire;

    kwd_regs u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .expire_i   (expire),
        .irq_i      (wdt_irq_o),
        .en_o       (mode_en),
        .code_o     (mode_code),
        .rst_sel_o  (rst_sel),
        .load_o     (load),
        .load_code_o(load_code),
        .halt_o     (halt),
        .irq_clr_o  (irq_clr),
        .rdata_o    (bus_rdata_o)
    );

    kwd_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .run_i      (mode_en),
        .load_i     (load),
        .load_code_i(load_code),
        .code_i     (mode_code),
        .halt_i     (halt),
        .expire_o   (expire)
    );

    kwd_expiry #(.PULSE_CYCLES(PULSE_CYCLES)) u_expiry (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .expire_i (expire),
        .rst_sel_i(rst_sel),
        .irq_clr_i(irq_clr),
        .rst_o    (wdt_rst_o),
        .irq_o    (wdt_irq_o)
    );
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
    import kwd_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_i,
    input logic [1:0]        addr_i,
    input logic [31:0]       wdata_i,
    input logic              en_i,
    input logic [CODE_W-1:0] code_i,
    input logic              expire_i,
    input logic              rst_o,
    input logic              irq_o
);
    localparam int HW = $clog2(PULSE_CYCLES + 2);

    logic [HW-1:0] hi_cnt;
    logic keyed, mode_key_wr, mode_bad_wr, cfg_clr_wr;

    assign keyed       = (wdata_i[31:16] == WR_KEY);
    assign mode_key_wr = wr_i && (addr_i == 2'd0) && keyed;
    assign mode_bad_wr = wr_i && (addr_i == 2'd0) && !keyed;
    assign cfg_clr_wr  = wr_i && (addr_i == 2'd1) && keyed && wdata_i[IRQ_BIT];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_cnt <= '0;
        end else if (rst_o) begin
            hi_cnt <= hi_cnt + HW'(1);
        end else begin
            hi_cnt <= '0;
        end
    end

    // R2: an unkeyed mode write leaves enable and code untouched
    a_r2_unkeyed_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_bad_wr && !expire_i) |=> $stable({en_i, code_i}));

    // R6: a keyed write with enable clear stops the block
    a_r6_halt_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_key_wr && !wdata_i[EN_BIT]) |=> !en_i);

    // R6: a disabled block never expires
    a_r6_idle_no_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> !expire_i);

    // R7: the reset pulse lasts exactly PULSE_CYCLES cycles
    a_r7_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_o) |-> (hi_cnt == HW'(PULSE_CYCLES)));

    // R7: a reset expiry switches the block off
    a_r7_pulse_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(rst_o) && !$past(mode_key_wr)) |-> !en_i);

    // R8: the interrupt flag holds until a keyed clear
    a_r8_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !cfg_clr_wr) |=> irq_o);
endmodule

bind keyed_watchdog kwd_checker #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .en_i    (mode_en),
    .code_i  (mode_code),
    .expire_i(expire),
    .rst_o   (wdt_rst_o),
    .irq_o   (wdt_irq_o)
);

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
    localparam int HALF = 4;
    localparam int PULSE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wrst, wirq;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    keyed_watchdog #(.HALF_TICKS(HALF), .PULSE_CYCLES(PULSE)) uut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .wdt_rst_o(wrst), .wdt_irq_o(wirq)
    );

    function automatic int exp_ticks(input logic [3:0] c);
        int h;
        if (c == 4'h0) h = 1;
        else if (c <= 4'h6) h = 2 * int'(c);
        else if (c <= 4'hB) h = 16 + 4 * (int'(c) - 7);
        else h = 32;
        return h * HALF;
    endfunction

    function automatic logic [31:0] mode_w(input logic en, input logic [3:0] c);
        return {16'h16AA, 8'h00, c, 3'b000, en};
    endfunction

    function automatic logic [31:0] cfg_w(input logic rst_act, input logic clr);
        return {16'h16AA, 7'd0, clr, 7'd0, rst_act};
    endfunction

    localparam logic [31:0] FEED_OK = {19'd0, 12'hA57, 1'b1};
    localparam logic [31:0] FEED_BAD = {19'd0, 12'hA56, 1'b1};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
        @(negedge clk);
    endtask

    task automatic quiesce();
        bus_write(2'd0, mode_w(1'b0, 4'h0));
        bus_write(2'd1, cfg_w(1'b1, 1'b1));
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        chk("R1 rst_o", 32'(wrst), 0);
        chk("R1 irq_o", 32'(wirq), 0);
        bus_read(2'd0, d); chk("R1 mode read", d, 0);
        bus_read(2'd1, d); chk("R1 cfg read", d, 32'h1);
    endtask

    task automatic t_unkeyed();
        logic [31:0] d;
        bus_write(2'd0, {16'h16AB, 8'h00, 4'h0, 3'b000, 1'b1});
        bus_write(2'd1, {16'h0000, 15'd0, 1'b0});
        idle(30);
        chk("R2 no expiry from unkeyed enable", 32'(wrst), 0);
        bus_read(2'd0, d); chk("R2 mode unchanged", d, 0);
        bus_read(2'd1, d); chk("R2 cfg unchanged", d, 32'h1);
    endtask

    task automatic t_reset_pulse();
        logic [31:0] d;
        int t = exp_ticks(4'h0);
        bus_write(2'd0, mode_w(1'b1, 4'h0));
        bus_read(2'd0, d); chk("R10 mode readback masks key", d, 32'h1);
        idle(t - 2);
        chk("R3 no reset before timeout", 32'(wrst), 0);
        idle(1);
        chk("R3 reset at timeout", 32'(wrst), 1);
        idle(PULSE - 1);
        chk("R7 pulse still high at last cycle", 32'(wrst), 1);
        idle(1);
        chk("R7 pulse ended", 32'(wrst), 0);
        bus_read(2'd0, d); chk("R7 enable cleared", d, 32'h0);
        idle(40);
        chk("R7 no second pulse", 32'(wrst), 0);
    endtask

    task automatic t_feed();
        int t = exp_ticks(4'h1);
        bus_write(2'd0, mode_w(1'b1, 4'h1));
        idle(5);
        bus_write(2'd2, FEED_OK);
        idle(t - 1);
        chk("R5 feed postponed expiry", 32'(wrst), 0);
        idle(1);
        chk("R5 expiry one period after feed", 32'(wrst), 1);
        idle(PULSE + 2);
        bus_write(2'd0, mode_w(1'b1, 4'h1));
        idle(5);
        bus_write(2'd2, FEED_BAD);
        idle(1);
        chk("R5 bad feed key: not yet", 32'(wrst), 0);
        idle(1);
        chk("R5 bad feed key ignored", 32'(wrst), 1);
        idle(PULSE + 2);
        bus_write(2'd2, FEED_OK);
        idle(40);
        chk("R5 feed while disabled does nothing", 32'({wrst, wirq}), 0);
    endtask

    task automatic t_halt();
        logic [31:0] d;
        bus_write(2'd0, mode_w(1'b1, 4'h0));
        idle(2);
        bus_write(2'd0, mode_w(1'b0, 4'h3));
        idle(40);
        chk("R6 halted: no reset", 32'(wrst), 0);
        bus_read(2'd0, d); chk("R6 mode after halt", d, 32'h30);
    endtask

    task automatic t_tick_gate();
        tick = 1'b0;
        bus_write(2'd0, mode_w(1'b1, 4'h0));
        idle(30);
        chk("R9 no progress without ticks", 32'(wrst), 0);
        tick = 1'b1;
        idle(exp_ticks(4'h0) - 1);
        chk("R9 counts ticks: not yet", 32'(wrst), 0);
        idle(1);
        chk("R9 expiry after enough ticks", 32'(wrst), 1);
        idle(PULSE + 2);
    endtask

    task automatic t_irq_mode();
        logic [31:0] d;
        int t = exp_ticks(4'h0);
        bus_write(2'd1, cfg_w(1'b0, 1'b1));
        bus_write(2'd0, mode_w(1'b1, 4'h0));
        idle(t - 1);
        chk("R8 irq low before timeout", 32'(wirq), 0);
        idle(1);
        chk("R8 irq set at timeout", 32'(wirq), 1);
        chk("R8 no reset in irq mode", 32'(wrst), 0);
        bus_write(2'd1, cfg_w(1'b0, 1'b1));
        chk("R8 keyed clear", 32'(wirq), 0);
        idle(t - 2);
        chk("R8 second period: not yet", 32'(wirq), 0);
        idle(1);
        chk("R8 counter reloaded and expired again", 32'(wirq), 1);
        bus_write(2'd1, {16'h0000, 7'd0, 1'b1, 8'd0});
        chk("R8 unkeyed clear ignored", 32'(wirq), 1);
        bus_read(2'd1, d); chk("R10 cfg readback", d, 32'h100);
        quiesce();
    endtask

    task automatic t_table();
        logic [3:0] codes [10] = '{4'h1, 4'h2, 4'h3, 4'h5, 4'h7, 4'h8, 4'hA, 4'hB, 4'hC, 4'hF};
        for (int i = 0; i < 10; i++) begin
            int t = exp_ticks(codes[i]);
            quiesce();
            bus_write(2'd1, cfg_w(1'b0, 1'b1));
            bus_write(2'd0, mode_w(1'b1, codes[i]));
            idle(t - 1);
            chk($sformatf("R4 code %0h before timeout", codes[i]), 32'(wirq), 0);
            idle(1);
            chk($sformatf("R4 code %0h at timeout", codes[i]), 32'(wirq), 1);
        end
        quiesce();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_unkeyed();
        t_reset_pulse();
        t_feed();
        t_halt();
        t_tick_gate();
        t_irq_mode();
        t_table();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule